// File: doc/BRIEF.md
# Two-Wire Request/Reply Handshake Link

This block joins a sending endpoint and a receiving endpoint over a shared data bus. Two control lines, request and reply, set the timing of every word. Each endpoint reads the other side's control line through a short synchronizer chain, so the two ends need no common timing. Every word moves in a full four-phase exchange: request rises, reply rises, request falls, reply falls. A new exchange starts only after reply has returned low.

The direction of initiation is chosen while reset is held. In sender-led operation the sender puts the word on the bus and then raises request. The receiver latches the bus and raises reply in the same cycle. In receiver-led operation the receiver raises request when it can take a word. The sender places the word on the bus and then answers with reply. The receiver latches the bus when it sees reply rise.

The sender takes words through a valid/ready interface. The receiver gives each word out with a one-cycle valid pulse, and its `rx_ready` input throttles the link. Only the sender drives the bus, through three-state drivers. The bus value, the bus enable and both control lines are brought out for observation.

Top module: `hs_link`

## Requirements
- R1: The initiation style is taken from `mode_sel` while `rst_n` is low: 0 selects sender-led and 1 selects receiver-led. Changes on `mode_sel` after reset has been released have no effect until the next reset.
- R2: In reset, and in the first cycle after it, `link_req`, `link_rep`, `bus_oe` and `rx_valid` are all low.
- R3: Each transfer follows the order request rise, reply rise, request fall, reply fall. Request never rises while reply is high. Reply never rises while request is low. Request never falls while reply is low. Reply never falls while request is high.
- R4: In sender-led mode, `tx_ready` is high only when the sender is idle and reply is low. After a word is accepted, `bus_oe` goes high with the word on `link_bus` one cycle before `link_req` rises.
- R5: In receiver-led mode, the receiver raises request only when `rx_ready` is high and reply is low. The sender raises `tx_ready` only while it sees request high. Reply rises only after the sender is driving an accepted word on the bus.
- R6: While `bus_oe` stays high, `link_bus` does not change. The bus stays driven until the sender sees the completing edge from the other side.
- R7: Each transfer gives exactly one `rx_valid` pulse of one cycle, with the transferred word on `rx_data`. Words arrive in the order they were sent.
- R8: In sender-led mode, while `rx_ready` is low, reply stays low and the sender keeps request high and its word on the bus. When `rx_ready` goes high, the held word is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | Initiation style, sampled during reset (0 sender-led, 1 receiver-led) |
| tx_data | input | DATA_W | Word offered to the sender |
| tx_valid | input | 1 | Word offered is valid |
| tx_ready | output | 1 | Sender accepts the offered word at this edge |
| rx_ready | input | 1 | Receiver may take a word |
| rx_data | output | DATA_W | Last word received |
| rx_valid | output | 1 | One-cycle pulse: a new word is on rx_data |
| link_req | output | 1 | Request line of the link |
| link_rep | output | 1 | Reply line of the link |
| link_bus | output | DATA_W | Value on the shared data bus |
| bus_oe | output | 1 | Sender is driving the bus |

## Verification
Assertions check on every cycle the four-phase order of request and reply, bus stability while it is driven, that the data bus is driven before a sender-led request, the single-cycle valid pulse, and the receiver-led conditions for raising request and reply. Only the bench scenarios can show that the delivered words match the sent ones in value and order. The same holds for back-pressure holding a word indefinitely, for a receiver-led sender waiting for a request before it takes a word, and for `mode_sel` being ignored after reset.

// File: rtl/hs_link_pkg.sv
// Shared types for the handshake link.
// Assumes: both endpoints run from the same clock and reset pins.
package hs_link_pkg;

    typedef enum logic [1:0] {
        SND_IDLE  = 2'd0,
        SND_SETUP = 2'd1,
        SND_HOLD  = 2'd2,
        SND_DONE  = 2'd3
    } snd_state_t;

    typedef enum logic [1:0] {
        RCV_IDLE    = 2'd0,
        RCV_WAIT_HI = 2'd1,
        RCV_WAIT_LO = 2'd2
    } rcv_state_t;

endpackage

// File: rtl/hs_link_sync.sv
// Multi-flop synchronizer for one handshake line.
// Assumes: STAGES >= 2; the output is cleared by reset.
module hs_link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the incoming level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_link_snd.sv
// Sending endpoint. It takes words on a valid/ready port, drives the shared
// bus and runs its half of the four-phase exchange. In sender-led mode its
// control output is request; in receiver-led mode it is reply.
// Assumes: hs_in is already synchronized; rcv_led is constant after reset.
module hs_link_snd
    import hs_link_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rcv_led,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              hs_in,
    output logic              hs_out,
    output logic              oe,
    output logic [DATA_W-1:0] word_q
);
    snd_state_t st;

    // Accept only when idle and the far line is in its resting/asking state.
    assign in_ready = (st == SND_IDLE) && (rcv_led ? hs_in : !hs_in);

    // Sender state machine: load, drive, signal, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SND_IDLE;
            hs_out <= 1'b0;
            oe     <= 1'b0;
            word_q <= '0;
        end else begin
            case (st)
                SND_IDLE: if (in_valid && in_ready) begin
                    word_q <= in_data;
                    oe     <= 1'b1;
                    st     <= SND_SETUP;
                end
                SND_SETUP: begin
                    hs_out <= 1'b1;
                    st     <= rcv_led ? SND_DONE : SND_HOLD;
                end
                SND_HOLD: if (hs_in) begin
                    hs_out <= 1'b0;
                    st     <= SND_DONE;
                end
                SND_DONE: if (!hs_in) begin
                    hs_out <= 1'b0;
                    oe     <= 1'b0;
                    st     <= SND_IDLE;
                end
                default: st <= SND_IDLE;
            endcase
        end
    end

    AST_REPLY_HAS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_led && $rose(hs_out)) |-> oe); // R5
    AST_REQ_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rcv_led && $rose(hs_out)) |-> $past(oe)); // R4
endmodule

// File: rtl/hs_link_rcv.sv
// Receiving endpoint. It latches the shared bus at the point fixed by the
// initiation style and presents each word with a one-cycle valid pulse.
// Assumes: hs_in is already synchronized; the bus is stable while valid.
module hs_link_rcv
    import hs_link_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rcv_led,
    input  logic              take_en,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              hs_in,
    output logic              hs_out,
    output logic [DATA_W-1:0] word_q,
    output logic              word_vld
);
    rcv_state_t st;

    // Receiver state machine: ask or answer, latch, then wait for rest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= RCV_IDLE;
            hs_out   <= 1'b0;
            word_q   <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            case (st)
                RCV_IDLE: begin
                    if (!rcv_led) begin
                        if (hs_in && take_en) begin
                            word_q   <= bus_in;
                            word_vld <= 1'b1;
                            hs_out   <= 1'b1;
                            st       <= RCV_WAIT_LO;
                        end
                    end else if (take_en && !hs_in) begin
                        hs_out <= 1'b1;
                        st     <= RCV_WAIT_HI;
                    end
                end
                RCV_WAIT_HI: if (hs_in) begin
                    word_q   <= bus_in;
                    word_vld <= 1'b1;
                    hs_out   <= 1'b0;
                    st       <= RCV_WAIT_LO;
                end
                RCV_WAIT_LO: if (!hs_in) begin
                    hs_out <= 1'b0;
                    st     <= RCV_IDLE;
                end
                default: st <= RCV_IDLE;
            endcase
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld); // R7
    AST_ASK_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_led && $rose(hs_out)) |-> $past(take_en)); // R5
endmodule

// File: rtl/hs_link.sv
// Top of the handshake link: sender, receiver, synchronizers, the
// three-state data bus and the routing of request/reply by mode.
// Assumes: mode_sel is settled while rst_n is low.
module hs_link
    import hs_link_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              link_req,
    output logic              link_rep,
    output logic [DATA_W-1:0] link_bus,
    output logic              bus_oe
);
    logic              rcv_led_q;
    logic              snd_out, rcv_out;
    logic              snd_in_s, rcv_in_s;
    logic [DATA_W-1:0] snd_word;
    wire  [DATA_W-1:0] data_bus;

    // Capture the initiation style only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) rcv_led_q <= mode_sel;
    end

    // Route each endpoint's control output onto request or reply.
    assign link_req = rcv_led_q ? rcv_out : snd_out;
    assign link_rep = rcv_led_q ? snd_out : rcv_out;

    // Three-state driver of the shared data bus.
    assign data_bus = bus_oe ? snd_word : {DATA_W{1'bz}};
    assign link_bus = data_bus;

    hs_link_sync #(.STAGES(SYNC_STAGES)) sync_to_snd_i (
        .clk(clk), .rst_n(rst_n), .d(rcv_out), .q(snd_in_s));

    hs_link_sync #(.STAGES(SYNC_STAGES)) sync_to_rcv_i (
        .clk(clk), .rst_n(rst_n), .d(snd_out), .q(rcv_in_s));

    hs_link_snd #(.DATA_W(DATA_W)) snd_i (
        .clk(clk), .rst_n(rst_n), .rcv_led(rcv_led_q),
        .in_data(tx_data), .in_valid(tx_valid), .in_ready(tx_ready),
        .hs_in(snd_in_s), .hs_out(snd_out), .oe(bus_oe), .word_q(snd_word));

    hs_link_rcv #(.DATA_W(DATA_W)) rcv_i (
        .clk(clk), .rst_n(rst_n), .rcv_led(rcv_led_q), .take_en(rx_ready),
        .bus_in(data_bus), .hs_in(rcv_in_s), .hs_out(rcv_out),
        .word_q(rx_data), .word_vld(rx_valid));

    AST_REQ_RISE_REP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_req) |-> !link_rep); // R3
    AST_REP_RISE_REQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_rep) |-> link_req); // R3
    AST_REQ_FALL_REP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_req) |-> link_rep); // R3
    AST_REP_FALL_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_rep) |-> !link_req); // R3
    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe)) |-> $stable(link_bus)); // R6
endmodule

// File: tb/hs_link_tb_top.sv
module hs_link_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_sel = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         tx_valid = 1'b0;
    logic         tx_ready;
    logic         rx_ready = 1'b0;
    logic [W-1:0] rx_data;
    logic         rx_valid;
    logic         link_req, link_rep, bus_oe;
    logic [W-1:0] link_bus;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] rx_log [0:63];
    int rx_cnt = 0;
    int proto_bad = 0;
    int stab_bad = 0;
    logic p_req = 1'b0, p_rep = 1'b0, p_oe = 1'b0;
    logic [W-1:0] p_bus = '0;

    always #2.5 clk = ~clk;

    hs_link #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .link_req(link_req), .link_rep(link_rep), .link_bus(link_bus),
        .bus_oe(bus_oe));

    // Collect delivered words and watch handshake order and bus stability.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && rx_cnt < 64) begin
                rx_log[rx_cnt] = rx_data;
                rx_cnt++;
            end
            if (link_req && !p_req && p_rep)  proto_bad++;
            if (link_rep && !p_rep && !p_req) proto_bad++;
            if (!link_req && p_req && !p_rep) proto_bad++;
            if (!link_rep && p_rep && p_req)  proto_bad++;
            if (bus_oe && p_oe && link_bus !== p_bus) stab_bad++;
            p_req = link_req; p_rep = link_rep; p_oe = bus_oe; p_bus = link_bus;
        end else begin
            p_req = 1'b0; p_rep = 1'b0; p_oe = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0; mode_sel = mode; tx_valid = 1'b0; rx_ready = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: first cycle after reset release
        check("R2 req", link_req, 0);
        check("R2 rep", link_rep, 0);
        check("R2 oe", bus_oe, 0);
        check("R2 valid", rx_valid, 0);
    endtask

    // Offer one word; returns once the sender has taken it.
    task automatic send_word(input logic [W-1:0] w, input bit check_setup);
        int n = 0;
        tx_data = w; tx_valid = 1'b1;
        while (!tx_ready && n < 500) begin @(negedge clk); n++; end
        @(negedge clk);
        tx_valid = 1'b0;
        if (check_setup) begin
            // R4: bus driven with the word before request rises
            check("R4 oe before req", bus_oe, 1);
            check("R4 req still low", link_req, 0);
            check("R4 bus word", link_bus, w);
        end
    endtask

    task automatic wait_rx(input int target);
        int n = 0;
        while (rx_cnt < target && n < 500) begin @(negedge clk); n++; end
    endtask

    task automatic t_sender_led_stream();
        logic [W-1:0] pat [0:4];
        int base;
        pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'hA5; pat[3] = 8'h5A; pat[4] = 8'h3C;
        do_reset(1'b0);
        rx_ready = 1'b1;
        base = rx_cnt;
        for (int i = 0; i < 5; i++) send_word(pat[i], i == 0);
        wait_rx(base + 5);
        check("R7 count", rx_cnt - base, 5);
        for (int i = 0; i < 5; i++) check("R7 word order", rx_log[base + i], pat[i]);
    endtask

    task automatic t_backpressure();
        int base = rx_cnt;
        rx_ready = 1'b0;
        send_word(8'h77, 1'b0);
        repeat (30) @(negedge clk);
        check("R8 req held", link_req, 1);
        check("R8 rep low", link_rep, 0);
        check("R8 bus held", link_bus, 8'h77);
        check("R8 oe held", bus_oe, 1);
        check("R4 not ready mid-transfer", tx_ready, 0);
        check("R8 nothing delivered", rx_cnt - base, 0);
        rx_ready = 1'b1;
        wait_rx(base + 1);
        check("R8 held word delivered", rx_log[base], 8'h77);
    endtask

    task automatic t_mode_ignored_sender();
        int base = rx_cnt;
        mode_sel = 1'b1;
        rx_ready = 1'b1;
        repeat (20) @(negedge clk);
        check("R1 no receiver request", link_req, 0);
        send_word(8'hC3, 1'b1);
        wait_rx(base + 1);
        check("R1 sender-led still works", rx_log[base], 8'hC3);
    endtask

    task automatic t_receiver_led();
        logic [W-1:0] pat [0:2];
        int base;
        pat[0] = 8'h11; pat[1] = 8'h80; pat[2] = 8'h01;
        do_reset(1'b1);
        base = rx_cnt;
        tx_data = 8'h99; tx_valid = 1'b1;
        repeat (20) @(negedge clk);
        check("R5 no request without room", link_req, 0);
        check("R5 sender waits", tx_ready, 0);
        check("R5 bus idle", bus_oe, 0);
        tx_valid = 1'b0;
        rx_ready = 1'b1;
        repeat (20) @(negedge clk);
        check("R5 request raised", link_req, 1);
        check("R5 no reply without word", link_rep, 0);
        check("R5 no delivery", rx_cnt - base, 0);
        for (int i = 0; i < 3; i++) send_word(pat[i], 1'b0);
        wait_rx(base + 3);
        for (int i = 0; i < 3; i++) check("R7 receiver-led word", rx_log[base + i], pat[i]);
        mode_sel = 1'b0;
        send_word(8'h4E, 1'b0);
        wait_rx(base + 4);
        check("R1 receiver-led kept", rx_log[base + 3], 8'h4E);
    endtask

    initial begin
        fork
            begin
                t_sender_led_stream();
                t_backpressure();
                t_mode_ignored_sender();
                t_receiver_led();
                repeat (10) @(negedge clk);
                check("R3 handshake order", proto_bad, 0);
                check("R6 bus stable", stab_bad, 0);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule